// File: doc/BRIEF.md
# Per-CPU Reloadable Countdown Timer

This block is a private 32-bit down-counter for one processor. Software programs it through four word registers: a reload value, the live count, a control word and a one-bit event flag. While enabled, the count drops by one every P+1 clock cycles, where P is an 8-bit divider held in the control word. When the count reaches zero the event flag is set, and the timer either restarts from the reload value or stays at zero and halts.

A one-cycle interrupt request is sent toward the interrupt controller only when the event flag goes from 0 to 1. Software acknowledges the event by writing 1 to the flag. A flag that is still set when another expiry occurs produces no further request. Read data is combinational from the address. A write takes effect at the clock edge on which `wr_en_i` is high.

Top module: `cpu_countdown_timer`

## Requirements
- R1: After reset the reload, count, control and flag registers all read 0 and `irq_o` is low.
- R2: A write to offset 0x0 (reload) stores the value as the reload value and also copies it into the live count.
- R3: A write to offset 0x4 (count) changes only the live count. The reload value keeps its value.
- R4: With control bit 0 (enable) set and a nonzero count, the count decrements once every P+1 cycles, where P is control bits [15:8]. The first decrement lands P+1 edges after the write that enabled it.
- R5: On the decrement that reaches zero, the flag (offset 0xC, bit 0) becomes 1. If control bit 1 (reload mode) is clear, the count then stays at zero.
- R6: In reload mode, the edge that expires the count loads the reload value, and counting continues from there.
- R7: When a control write raises the enable bit while the count is zero and the written reload-mode bit is 1, the count is first loaded from the reload value.
- R8: Writing the flag register clears bit 0 if the written bit 0 is 1. Writing 0 leaves the flag unchanged.
- R9: `irq_o` is high for exactly one cycle, in the first cycle in which the flag reads 1 after having been 0. Expiries while the flag is already set, and clears, raise no request.
- R10: Reading the count returns 0 when the timer is disabled or the count is zero. Any offset other than 0x0, 0x4, 0x8 and 0xC reads 0.
- R11: If a flag clear and an expiry happen on the same edge, the flag stays 1 and no request is raised.
- R12: Any register write to reload, count or control restarts the divider phase, so the next decrement comes a full P+1 cycles after that write.
- R13: The control register reads back bits [15:8], 1 and 0 as written. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | ADDR_W (8) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | One-cycle interrupt request on a new event |

## Verification
Two functions can land on the same edge: a software clear of the event flag and a reload-mode expiry that sets the flag again. The bench uses a divider of 0 and a fixed reload value, so the expiry edges are fully predictable. It times a write of 1 to the flag so that the write lands exactly on an expiry edge. It then expects the flag to read 1 and the scoreboard to see no interrupt pulse on that edge. A later clear on a quiet edge must be followed by exactly one pulse on the next expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W       = 8;
    localparam int PRE_LSB     = 8;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_RL_BIT = 1;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic             reload;
        logic             en;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             step_o
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        step_o = 1'b0;
        if (restart_i || !run_i) begin
            st_d.phase = '0;
        end else if (st_q.phase == div_i) begin
            step_o     = 1'b1;
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_reload_i,
    input  logic              wr_count_i,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  ctrl_t             ctrl_wdata_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output ctrl_t             ctrl_o,
    output logic              run_o,
    output logic              expire_o
);

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] count;
        ctrl_t             ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        run_o    = st_q.ctrl.en && (st_q.count != '0);

        // The divider never steps on a cycle with a register write,
        // so the countdown and the writes below are exclusive.
        if (step_i && run_o) begin
            if (st_q.count == DATA_W'(1)) begin
                expire_o   = 1'b1;
                st_d.count = st_q.ctrl.reload ? st_q.reload : '0;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end

        if (wr_reload_i) begin
            st_d.reload = wdata_i;
            st_d.count  = wdata_i;
        end

        if (wr_count_i) begin
            st_d.count = wdata_i;
        end

        if (wr_ctrl_i) begin
            st_d.ctrl = ctrl_wdata_i;
            if (!st_q.ctrl.en && ctrl_wdata_i.en && ctrl_wdata_i.reload &&
                (st_q.count == '0)) begin
                st_d.count = st_q.reload;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign ctrl_o   = st_q.ctrl;

endmodule

// File: rtl/tmr_event.sv
module tmr_event (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);

    typedef struct packed {
        logic flag;
        logic irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // A new expiry outranks a clear on the same edge.
        st_d.flag = set_i | (st_q.flag & ~clr_i);
        st_d.irq  = st_d.flag & ~st_q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/cpu_countdown_timer.sv
module cpu_countdown_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic              upper_zero;
    logic              addr_hit;
    reg_sel_e          sel;
    logic              wr_reload, wr_count, wr_ctrl, wr_flag, wr_cnt_any;
    ctrl_t             ctrl_wdata, ctrl_q;
    logic [DATA_W-1:0] reload_q, count_q;
    logic              run, step, expire, flag_q;

    generate
        if (ADDR_W > 4) begin : g_wide_addr
            assign upper_zero = (addr_i[ADDR_W-1:4] == '0);
        end else begin : g_narrow_addr
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign addr_hit   = upper_zero && (addr_i[1:0] == 2'b00);
    assign sel        = reg_sel_e'(addr_i[3:2]);
    assign wr_reload  = wr_en_i && addr_hit && (sel == SEL_RELOAD);
    assign wr_count   = wr_en_i && addr_hit && (sel == SEL_COUNT);
    assign wr_ctrl    = wr_en_i && addr_hit && (sel == SEL_CTRL);
    assign wr_flag    = wr_en_i && addr_hit && (sel == SEL_FLAG);
    assign wr_cnt_any = wr_reload | wr_count | wr_ctrl;

    assign ctrl_wdata.div    = wdata_i[PRE_LSB +: PRE_W];
    assign ctrl_wdata.reload = wdata_i[CTRL_RL_BIT];
    assign ctrl_wdata.en     = wdata_i[CTRL_EN_BIT];

    tmr_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (wr_cnt_any),
        .div_i     (ctrl_q.div),
        .step_o    (step)
    );

    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_reload_i  (wr_reload),
        .wr_count_i   (wr_count),
        .wr_ctrl_i    (wr_ctrl),
        .wdata_i      (wdata_i),
        .ctrl_wdata_i (ctrl_wdata),
        .step_i       (step),
        .reload_o     (reload_q),
        .count_o      (count_q),
        .ctrl_o       (ctrl_q),
        .run_o        (run),
        .expire_o     (expire)
    );

    tmr_event u_event (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (expire),
        .clr_i  (wr_flag & wdata_i[0]),
        .flag_o (flag_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_hit) begin
            unique case (sel)
                SEL_RELOAD: rdata_o = reload_q;
                SEL_COUNT:  rdata_o = run ? count_q : '0;
                SEL_CTRL: begin
                    rdata_o[PRE_LSB +: PRE_W] = ctrl_q.div;
                    rdata_o[CTRL_RL_BIT]      = ctrl_q.reload;
                    rdata_o[CTRL_EN_BIT]      = ctrl_q.en;
                end
                SEL_FLAG:   rdata_o[0] = flag_q;
                default:    rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/cpu_countdown_timer_chk.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              clr_bit_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic              irq_i,
    input logic              flag_i,
    input logic              expire_i,
    input logic [DATA_W-1:0] count_i,
    input logic [DATA_W-1:0] reload_i,
    input logic              en_i,
    input logic              rl_i,
    input logic              cnt_wr_i
);

    logic sel_count, sel_ctrl, clr_wr;
    assign sel_count = (addr_i == ADDR_W'(4));
    assign sel_ctrl  = (addr_i == ADDR_W'(8));
    assign clr_wr    = wr_en_i && (addr_i == ADDR_W'(12)) && clr_bit_i;

    // R4: without a write, the count only steps down by one or reloads
    p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(count_i) && !$past(cnt_wr_i)) |->
            ((count_i == $past(count_i) - DATA_W'(1)) || (count_i == reload_i)));

    p_expire_sets_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> flag_i);

    p_oneshot_halt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_i && !rl_i) |=> (count_i == '0));

    p_reload_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_i && rl_i) |=> (count_i == reload_i));

    p_clear_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && !expire_i) |=> !flag_i);

    p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |=> !irq_i);

    p_irq_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (flag_i && !$past(flag_i)));

    p_count_rd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_count && !en_i) |-> (rdata_i == '0));

    p_same_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && expire_i) |=> (flag_i && !irq_i));

    p_ctrl_rsvd_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_ctrl |-> ((rdata_i[DATA_W-1:PRE_LSB+PRE_W] == '0) &&
                      (rdata_i[PRE_LSB-1:2] == '0)));

endmodule

bind cpu_countdown_timer tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .clr_bit_i (wdata_i[0]),
    .rdata_i   (rdata_o),
    .irq_i     (irq_o),
    .flag_i    (flag_q),
    .expire_i  (expire),
    .count_i   (count_q),
    .reload_i  (reload_q),
    .en_i      (ctrl_q.en),
    .rl_i      (ctrl_q.reload),
    .cnt_wr_i  (wr_cnt_any)
);

// File: tb/cpu_countdown_timer_tb.sv
`timescale 1ns/1ps
module cpu_countdown_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_irq[$];
    bit done = 0;

    cpu_countdown_timer u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every request pulse must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && irq) begin
            n_chk++;
            if (exp_irq.size() == 0) begin
                n_fail++;
                $display("FAIL R9: request at cycle %0d, expected none", cyc);
            end else begin
                int e;
                e = exp_irq.pop_front();
                if (e != cyc) begin
                    n_fail++;
                    $display("FAIL R9: request at cycle %0d, expected cycle %0d", cyc, e);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
        addr = a;
        #0.5;
        n_chk++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: offset %h read %h, expected %h", req, a, rdata, e);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        summary();
    end

    initial begin
        int c0, c1, c2, cw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h04, 32'h0, "R1");
        rd_chk(8'h08, 32'h0, "R1");
        rd_chk(8'h0C, 32'h0, "R1");
        n_chk++;
        if (irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: irq %b, expected 0", irq);
        end

        // R13: control readback masks unused bits
        wr(8'h08, 32'hABCD_FF02);
        rd_chk(8'h08, 32'h0000_FF02, "R13");
        wr(8'h08, 32'h0);

        // R2, R10, R3
        wr(8'h00, 32'h0000_1234);
        rd_chk(8'h00, 32'h0000_1234, "R2");
        rd_chk(8'h04, 32'h0, "R10");
        wr(8'h08, 32'h0000_FF01);
        rd_chk(8'h04, 32'h0000_1234, "R2");
        wr(8'h04, 32'h0000_0050);
        rd_chk(8'h04, 32'h0000_0050, "R3");
        rd_chk(8'h00, 32'h0000_1234, "R3");
        wr(8'h08, 32'h0);
        rd_chk(8'h04, 32'h0, "R10");
        rd_chk(8'h10, 32'h0, "R10");
        rd_chk(8'h06, 32'h0, "R10");

        // R4, R5: one-shot, divider 2, count 3 -> expiry 9 edges on
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h0000_0201);
        c0 = cyc;
        exp_irq.push_back(c0 + 9);
        rd_chk(8'h04, 32'd3, "R4");
        wait_to(c0 + 3);
        rd_chk(8'h04, 32'd2, "R4");
        wait_to(c0 + 8);
        rd_chk(8'h04, 32'd1, "R4");
        wait_to(c0 + 9);
        rd_chk(8'h0C, 32'd1, "R5");
        rd_chk(8'h04, 32'd0, "R5");
        wait_to(c0 + 15);
        rd_chk(8'h04, 32'd0, "R5");
        rd_chk(8'h0C, 32'd1, "R5");

        // R8: write-one-to-clear
        wr(8'h0C, 32'h0);
        rd_chk(8'h0C, 32'd1, "R8");
        wr(8'h0C, 32'h1);
        rd_chk(8'h0C, 32'd0, "R8");

        // R7, R6: enable with zero count in reload mode, divider 0
        wr(8'h08, 32'h0);
        wr(8'h00, 32'd5);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'h0000_0003);
        c1 = cyc;
        exp_irq.push_back(c1 + 5);
        rd_chk(8'h04, 32'd5, "R7");
        wait_to(c1 + 7);
        rd_chk(8'h04, 32'd3, "R6");
        wait_to(c1 + 10);
        rd_chk(8'h0C, 32'd1, "R9");

        // R11: clear lands on the expiry edge c1+15
        wait_to(c1 + 14);
        wr(8'h0C, 32'h1);
        rd_chk(8'h0C, 32'd1, "R11");
        wait_to(c1 + 17);
        wr(8'h0C, 32'h1);
        rd_chk(8'h0C, 32'd0, "R8");
        exp_irq.push_back(c1 + 20);
        wait_to(c1 + 21);
        rd_chk(8'h0C, 32'd1, "R9");

        // R12: count write restarts the divider phase
        wr(8'h08, 32'h0);
        wr(8'h04, 32'd10);
        wr(8'h08, 32'h0000_0401);
        c2 = cyc;
        wait_to(c2 + 2);
        wr(8'h04, 32'd10);
        cw = cyc;
        wait_to(cw + 4);
        rd_chk(8'h04, 32'd10, "R12");
        wait_to(cw + 5);
        rd_chk(8'h04, 32'd9, "R12");
        wr(8'h08, 32'h0);

        repeat (5) @(negedge clk);
        n_chk++;
        if (exp_irq.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d requests missing, expected 0", exp_irq.size());
        end
        summary();
    end

endmodule